// File: doc/BRIEF.md
# Two-Gate Chute Sequencer

This block is a clocked Moore state machine that passes one animal at a time through a chute. The chute has an entry gate, an exit gate, a tag reader, an external countdown timer and an air valve that prods an animal that stays too long. Three status bits come in: the reader has finished (`scan_done`), an animal is in the chute (`animal_in`) and the timer has run out (`timer_up`). Five control bits go out: entry gate up, exit gate up, a 2-bit timer command and air valve open.

The state is held one-hot in six flip-flops, and every output is decoded from the state bits alone. The cycle runs as follows. The entry gate stays open until an animal arrives. The gates then stay shut until the reader finishes. The exit gate opens and a long timeout is loaded. If the animal is still inside when that timeout runs out, a short timeout is loaded and air blows until it runs out. The long timeout is then loaded again, so the prod repeats for as long as the animal lingers.

The timer command uses this encoding: 00 stop, 01 load the long (30 s) interval, 10 load the short (3 s) interval, 11 count down. A load command lasts exactly one clock cycle.

The states, with their one-hot codes, are:
- ADMIT = 000001
- SCAN = 000010
- ARM_LONG = 000100
- EXIT_WAIT = 001000
- ARM_SHORT = 010000
- BLAST = 100000

The transitions are:
- ADMIT→ADMIT when there is no animal, ADMIT→SCAN when an animal is present.
- SCAN→SCAN while the read is pending, SCAN→ARM_LONG when the read is done.
- ARM_LONG→EXIT_WAIT always.
- EXIT_WAIT→ADMIT when the animal has left, EXIT_WAIT→ARM_SHORT when the animal is present and the timer is up, EXIT_WAIT→EXIT_WAIT otherwise.
- ARM_SHORT→BLAST always.
- BLAST→BLAST while the timer runs, BLAST→ARM_LONG when the timer is up.

An illegal (non-one-hot) state pattern returns to ADMIT on the next edge.

Top module: `chute_seq`

## Requirements
- R1: An active-high synchronous reset puts the block in ADMIT (000001). The cycle after reset the outputs read entry=1, exit=0, timer=00, air=0.
- R2: Exactly one of the six state bits is high at all times out of reset, so the outputs always equal exactly one row of the R8 table.
- R3: In ADMIT the block stays while `animal_in`=0 and moves to SCAN on an edge with `animal_in`=1, whatever the other inputs are.
- R4: In SCAN the block stays while `scan_done`=0 and moves to ARM_LONG on an edge with `scan_done`=1, whatever the other inputs are.
- R5: ARM_LONG and ARM_SHORT each last one cycle. ARM_LONG always goes to EXIT_WAIT and ARM_SHORT always goes to BLAST, whatever the inputs are.
- R6: In EXIT_WAIT, `animal_in`=0 goes to ADMIT whatever `timer_up` is. `animal_in`=1 with `timer_up`=1 goes to ARM_SHORT. `animal_in`=1 with `timer_up`=0 stays.
- R7: In BLAST the block stays while `timer_up`=0 and goes to ARM_LONG on `timer_up`=1, whatever `animal_in` and `scan_done` are.
- R8: Outputs as entry, exit, timer[1:0], air are:
  - ADMIT = 1,0,00,0
  - SCAN = 0,0,00,0
  - ARM_LONG = 0,1,01,0
  - EXIT_WAIT = 0,1,11,0
  - ARM_SHORT = 0,1,10,0
  - BLAST = 0,1,11,1
- R9: Outputs depend only on the state. A change of any input between clock edges leaves every output unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_done | input | 1 | Tag reader has finished with the current animal |
| animal_in | input | 1 | An animal is inside the chute |
| timer_up | input | 1 | External timer has run out |
| entry_gate_up | output | 1 | Hold the entry gate raised |
| exit_gate_up | output | 1 | Hold the exit gate raised |
| timer_cmd | output | 2 | 00 stop, 01 load long, 10 load short, 11 count |
| air_open | output | 1 | Air valve open |

## Verification
In EXIT_WAIT the departure of the animal and the end of the long timeout can land on the same edge. The bench provokes this by driving `animal_in`=0 together with `timer_up`=1, both in the full sweep and at the end of a two-burst lingering run. It judges the outcome by the outputs one edge later, which must show the ADMIT row (entry gate up) and not the ARM_SHORT row (timer 10). The sweep likewise covers BLAST with `timer_up` and `animal_in` changing together, where only the timer may decide.

// File: rtl/chute_seq_pkg.sv
package chute_seq_pkg;

    localparam int PHASE_W = 6;
    localparam int TCMD_W  = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_ADMIT     = 6'b000001,
        PH_SCAN      = 6'b000010,
        PH_ARM_LONG  = 6'b000100,
        PH_EXIT_WAIT = 6'b001000,
        PH_ARM_SHORT = 6'b010000,
        PH_BLAST     = 6'b100000
    } phase_e;

    localparam logic [TCMD_W-1:0] TMR_STOP       = 2'b00;
    localparam logic [TCMD_W-1:0] TMR_LOAD_LONG  = 2'b01;
    localparam logic [TCMD_W-1:0] TMR_LOAD_SHORT = 2'b10;
    localparam logic [TCMD_W-1:0] TMR_RUN        = 2'b11;

    typedef struct packed {
        logic              entry_up;
        logic              exit_up;
        logic [TCMD_W-1:0] tcmd;
        logic              air;
    } ctrl_t;

endpackage

// File: rtl/chute_seq_state_reg.sv
module chute_seq_state_reg
    import chute_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_d,
    output phase_e phase_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADMIT;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/chute_seq_next.sv
module chute_seq_next
    import chute_seq_pkg::*;
(
    input  phase_e cur,
    input  logic   scan_done,
    input  logic   animal_in,
    input  logic   timer_up,
    output phase_e nxt
);

    always_comb begin
        nxt = PH_ADMIT;
        unique case (cur)
            PH_ADMIT:     nxt = animal_in ? PH_SCAN : PH_ADMIT;
            PH_SCAN:      nxt = scan_done ? PH_ARM_LONG : PH_SCAN;
            PH_ARM_LONG:  nxt = PH_EXIT_WAIT;
            PH_EXIT_WAIT: begin
                // departure outranks timeout
                if (!animal_in) begin
                    nxt = PH_ADMIT;
                end else if (timer_up) begin
                    nxt = PH_ARM_SHORT;
                end else begin
                    nxt = PH_EXIT_WAIT;
                end
            end
            PH_ARM_SHORT: nxt = PH_BLAST;
            PH_BLAST:     nxt = timer_up ? PH_ARM_LONG : PH_BLAST;
            default:      nxt = PH_ADMIT; // corrupt pattern recovers
        endcase
    end

endmodule

// File: rtl/chute_seq_decode.sv
module chute_seq_decode
    import chute_seq_pkg::*;
(
    input  phase_e cur,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (cur)
            PH_ADMIT:     ctrl = '{entry_up: 1'b1, exit_up: 1'b0, tcmd: TMR_STOP,       air: 1'b0};
            PH_SCAN:      ctrl = '{entry_up: 1'b0, exit_up: 1'b0, tcmd: TMR_STOP,       air: 1'b0};
            PH_ARM_LONG:  ctrl = '{entry_up: 1'b0, exit_up: 1'b1, tcmd: TMR_LOAD_LONG,  air: 1'b0};
            PH_EXIT_WAIT: ctrl = '{entry_up: 1'b0, exit_up: 1'b1, tcmd: TMR_RUN,        air: 1'b0};
            PH_ARM_SHORT: ctrl = '{entry_up: 1'b0, exit_up: 1'b1, tcmd: TMR_LOAD_SHORT, air: 1'b0};
            PH_BLAST:     ctrl = '{entry_up: 1'b0, exit_up: 1'b1, tcmd: TMR_RUN,        air: 1'b1};
            default:      ctrl = '0;
        endcase
    end

endmodule

// File: rtl/chute_seq.sv
module chute_seq
    import chute_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_done,
    input  logic       animal_in,
    input  logic       timer_up,
    output logic       entry_gate_up,
    output logic       exit_gate_up,
    output logic [1:0] timer_cmd,
    output logic       air_open
);

    phase_e phase_q;
    phase_e phase_d;
    ctrl_t  ctrl;

    chute_seq_state_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .phase_q (phase_q)
    );

    chute_seq_next u_next (
        .cur       (phase_q),
        .scan_done (scan_done),
        .animal_in (animal_in),
        .timer_up  (timer_up),
        .nxt       (phase_d)
    );

    chute_seq_decode u_dec (
        .cur  (phase_q),
        .ctrl (ctrl)
    );

    assign entry_gate_up = ctrl.entry_up;
    assign exit_gate_up  = ctrl.exit_up;
    assign timer_cmd     = ctrl.tcmd;
    assign air_open      = ctrl.air;

endmodule

// File: rtl/chute_seq_chk.sv
module chute_seq_chk
    import chute_seq_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         scan_done,
    input logic         animal_in,
    input logic         timer_up,
    input logic         entry_gate_up,
    input logic         exit_gate_up,
    input logic [1:0]   timer_cmd,
    input logic         air_open,
    input logic [5:0]   phase_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_q == PH_ADMIT && entry_gate_up && !exit_gate_up));

    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_q));

    // R3
    admit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ADMIT && !animal_in) |=> (phase_q == PH_ADMIT));

    // R4
    scan_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SCAN && scan_done) |=> (timer_cmd == TMR_LOAD_LONG));

    // R5
    short_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_cmd == TMR_LOAD_SHORT) |=> air_open);

    // R6
    leave_first_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXIT_WAIT && !animal_in) |=> entry_gate_up);

    // R7
    blast_end_chk: assert property (@(posedge clk) disable iff (rst)
        (air_open && timer_up) |=> (timer_cmd == TMR_LOAD_LONG));

    // R8
    gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(entry_gate_up && exit_gate_up));

    // R8
    air_run_chk: assert property (@(posedge clk) disable iff (rst)
        air_open |-> (exit_gate_up && timer_cmd == TMR_RUN));

endmodule

bind chute_seq chute_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scan_done     (scan_done),
    .animal_in     (animal_in),
    .timer_up      (timer_up),
    .entry_gate_up (entry_gate_up),
    .exit_gate_up  (exit_gate_up),
    .timer_cmd     (timer_cmd),
    .air_open      (air_open),
    .phase_q       (phase_q)
);

// File: tb/chute_seq_test.sv
module chute_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_done = 1'b0;
    logic       animal_in = 1'b0;
    logic       timer_up = 1'b0;
    logic       entry_gate_up;
    logic       exit_gate_up;
    logic [1:0] timer_cmd;
    logic       air_open;

    int checks = 0;
    int errors = 0;
    int model  = 0;  // 0 admit,1 scan,2 arm long,3 exit wait,4 arm short,5 blast
    bit done   = 1'b0;

    always #5 clk = ~clk;

    chute_seq uut (
        .clk           (clk),
        .rst           (rst),
        .scan_done     (scan_done),
        .animal_in     (animal_in),
        .timer_up      (timer_up),
        .entry_gate_up (entry_gate_up),
        .exit_gate_up  (exit_gate_up),
        .timer_cmd     (timer_cmd),
        .air_open      (air_open)
    );

    function automatic logic [4:0] row(input int s);
        case (s)
            0:       return 5'b1_0_00_0;
            1:       return 5'b0_0_00_0;
            2:       return 5'b0_1_01_0;
            3:       return 5'b0_1_11_0;
            4:       return 5'b0_1_10_0;
            default: return 5'b0_1_11_1;
        endcase
    endfunction

    function automatic int step_model(input int s, input bit r, input bit c, input bit t);
        case (s)
            0:       return c ? 1 : 0;
            1:       return r ? 2 : 1;
            2:       return 3;
            3:       return !c ? 0 : (t ? 4 : 3);
            4:       return 5;
            default: return t ? 2 : 5;
        endcase
    endfunction

    function automatic string tag(input int s);
        case (s)
            0:       return "R3";
            1:       return "R4";
            2, 4:    return "R5";
            3:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [4:0] outs();
        return {entry_gate_up, exit_gate_up, timer_cmd, air_open};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit r, input bit c, input bit t);
        int prev;
        scan_done = r; animal_in = c; timer_up = t;
        #1;
        check("R9 outputs moved without an edge", row(model));
        @(posedge clk);
        @(negedge clk);
        prev  = model;
        model = step_model(prev, r, c, t);
        check({tag(prev), "/R2/R8 transition"}, row(model));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
        check("R1 reset state", row(0));
    endtask

    task automatic go_to(input int s);
        do_reset();
        if (s >= 1) step(1'b0, 1'b1, 1'b0);
        if (s >= 2) step(1'b1, 1'b1, 1'b0);
        if (s >= 3) step(1'b0, 1'b1, 1'b0);
        if (s >= 4) step(1'b0, 1'b1, 1'b1);
        if (s >= 5) step(1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R3..R7: every state against every input combination
        for (int s = 0; s < 6; s++) begin
            for (int v = 0; v < 8; v++) begin
                go_to(s);
                step(v[2], v[1], v[0]);
            end
        end

        // lingering animal: two full burst cycles, then leaves as timer expires (R6, R7)
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 2; k++) begin
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b1, 1'b0);
        end
        step(1'b0, 1'b0, 1'b1);
        if (model != 0) begin
            errors++;
            $display("FAIL R6: model state %0d expected 0", model);
        end

        // R1: reset taken from the middle of a burst
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        do_reset();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule